// File: doc/BRIEF.md
# Tiled View Address Generator

This unit turns a pixel position inside a two-dimensional tiled container into the address used to reach that pixel through one of eight view orientations. A client presents a pixel format code, a three-bit orientation code and an X/Y coordinate. One clock later the unit returns the tiled-space address, the distance in bytes between two lines seen through that view, and a flag raised when the coordinate is out of range or the format code is not one of the tiled formats.

Each tiled format leaves a fixed number of low coordinate bits unused: none for 8-bit pixels, one in Y for 16-bit pixels, and one in each axis for 32-bit pixels. These per-format shifts narrow the legal coordinate range and widen the byte offset. The orientation code can mirror X, mirror Y and swap the axes. Together they select how X and Y are folded into the low address bits. The format and orientation codes are then placed in the top address bits, where downstream routing decodes them.

Top module: `tiled_addr_gen`

## Requirements
- R1: All three outputs are registered. The values sampled on a rising clock edge appear after that edge and hold until the next edge. While rst_n is low, addr, stride and invalid are all zero.
- R2: For a legal request, addr[31:29] equals the orientation code and addr[28:27] equals the format code. The format codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit pixels.
- R3: The shifts (xs, ys) are (0,0) for format 0, (0,1) for format 1 and (1,1) for format 2. The legal X width is 14-xs bits and the legal Y width is 13-ys bits.
- R4: An X above 2^(14-xs)-1 or a Y above 2^(13-ys)-1 raises invalid and forces addr to zero.
- R5: Format code 3 always raises invalid and forces both addr and stride to zero.
- R6: Orientation bit 0 replaces X by (X mask - X). Orientation bit 1 replaces Y by (Y mask - Y).
- R7: With orientation bit 2 set, the linear offset is (X' shifted left by the Y width) + Y'. With bit 2 clear, it is (Y' shifted left by the X width) + X'. Here X' and Y' are the values after mirroring.
- R8: The linear offset is shifted left by xs+ys and placed in addr[26:0].
- R9: For formats 0 to 2, stride is 1<<(13+xs) when bit 2 is set and 1<<(14+ys) when it is clear. Stride is given even when the coordinate is out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 2 | Pixel format code |
| orient | input | 3 | View orientation code: bit0 X mirror, bit1 Y mirror, bit2 axis swap |
| x | input | 16 | Pixel X coordinate |
| y | input | 16 | Pixel Y coordinate |
| addr | output | 32 | Tiled-space address |
| stride | output | 32 | Line stride for the selected view |
| invalid | output | 1 | Coordinate out of range or format not tiled |

## Verification
All three results come from one register stage, so each is due exactly one rising edge after its inputs are sampled. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. One check also reads just before the rising edge, to confirm that a new input has not yet reached the outputs. Expected values come from a model in the bench written directly from the requirements. Two cases are also checked against hand-computed constants.

// File: rtl/tva_pkg.sv
package tva_pkg;
    typedef enum logic [1:0] {
        PIX_8  = 2'd0,
        PIX_16 = 2'd1,
        PIX_32 = 2'd2,
        PIX_NA = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] xs;
        logic [1:0] ys;
    } fmt_geom_t;
endpackage

// File: rtl/tva_geom.sv
module tva_geom
    import tva_pkg::*;
(
    input  logic [1:0] fmt,
    output fmt_geom_t  geom
);
    always_comb begin
        geom = '0;
        unique case (pix_fmt_e'(fmt))
            PIX_8:  geom = '{ok: 1'b1, xs: 2'd0, ys: 2'd0};
            PIX_16: geom = '{ok: 1'b1, xs: 2'd0, ys: 2'd1};
            PIX_32: geom = '{ok: 1'b1, xs: 2'd1, ys: 2'd1};
            default: geom = '{ok: 1'b0, xs: 2'd0, ys: 2'd0};
        endcase
    end
endmodule

// File: rtl/tva_axis.sv
module tva_axis #(
    parameter int CBITS   = 14,
    parameter int COORD_W = 16,
    localparam int BW     = $clog2(CBITS + 1)
) (
    input  logic [COORD_W-1:0] coord,
    input  logic [1:0]         shift,
    input  logic               mirror,
    output logic [CBITS-1:0]   value,
    output logic [BW-1:0]      bits,
    output logic               over
);
    logic [CBITS-1:0]   mask;
    logic [COORD_W-1:0] mask_ext;

    always_comb begin
        mask     = {CBITS{1'b1}} >> shift;
        mask_ext = COORD_W'(mask);
        over     = coord > mask_ext;
        bits     = BW'(CBITS) - BW'(shift);
        value    = mirror ? (mask - coord[CBITS-1:0]) : coord[CBITS-1:0];
    end
endmodule

// File: rtl/tva_pack.sv
module tva_pack #(
    parameter int CX_BITS = 14,
    parameter int CY_BITS = 13,
    localparam int OW     = CX_BITS + CY_BITS,
    localparam int AW     = OW + 5,
    localparam int BXW    = $clog2(CX_BITS + 1),
    localparam int BYW    = $clog2(CY_BITS + 1)
) (
    input  logic [CX_BITS-1:0] xv,
    input  logic [CY_BITS-1:0] yv,
    input  logic [BXW-1:0]     xbits,
    input  logic [BYW-1:0]     ybits,
    input  logic               flip,
    input  logic [2:0]         align,
    input  logic [1:0]         fmt,
    input  logic [2:0]         orient,
    output logic [AW-1:0]      addr
);
    logic [OW-1:0] lin;
    logic [OW-1:0] scaled;

    always_comb begin
        if (flip) lin = (OW'(xv) << ybits) + OW'(yv);
        else      lin = (OW'(yv) << xbits) + OW'(xv);
        scaled = lin << align;
        addr   = {orient, fmt, scaled};
    end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
    import tva_pkg::*;
#(
    parameter int CX_BITS = 14,
    parameter int CY_BITS = 13,
    parameter int COORD_W = 16,
    localparam int AW     = CX_BITS + CY_BITS + 5,
    localparam int BXW    = $clog2(CX_BITS + 1),
    localparam int BYW    = $clog2(CY_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         fmt,
    input  logic [2:0]         orient,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [AW-1:0]      addr,
    output logic [AW-1:0]      stride,
    output logic               invalid
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] stride;
        logic          bad;
    } res_t;

    fmt_geom_t         geom;
    logic [CX_BITS-1:0] xv;
    logic [CY_BITS-1:0] yv;
    logic [BXW-1:0]    xbits;
    logic [BYW-1:0]    ybits;
    logic              xover, yover;
    logic [AW-1:0]     packed_addr;
    res_t              res_d, res_q;

    tva_geom u_geom (.fmt(fmt), .geom(geom));

    tva_axis #(.CBITS(CX_BITS), .COORD_W(COORD_W)) u_xaxis (
        .coord(x), .shift(geom.xs), .mirror(orient[0]),
        .value(xv), .bits(xbits), .over(xover)
    );

    tva_axis #(.CBITS(CY_BITS), .COORD_W(COORD_W)) u_yaxis (
        .coord(y), .shift(geom.ys), .mirror(orient[1]),
        .value(yv), .bits(ybits), .over(yover)
    );

    tva_pack #(.CX_BITS(CX_BITS), .CY_BITS(CY_BITS)) u_pack (
        .xv(xv), .yv(yv), .xbits(xbits), .ybits(ybits),
        .flip(orient[2]), .align({1'b0, geom.xs} + {1'b0, geom.ys}),
        .fmt(fmt), .orient(orient), .addr(packed_addr)
    );

    always_comb begin
        res_d     = '0;
        res_d.bad = !geom.ok || xover || yover;
        if (geom.ok) begin
            if (orient[2]) res_d.stride = AW'(1) << (CY_BITS + int'(geom.xs));
            else           res_d.stride = AW'(1) << (CX_BITS + int'(geom.ys));
        end
        res_d.addr = res_d.bad ? '0 : packed_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign addr    = res_q.addr;
    assign stride  = res_q.stride;
    assign invalid = res_q.bad;
endmodule

// File: rtl/tva_chk.sv
module tva_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    fmt,
    input logic [2:0]    orient,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] stride,
    input logic          invalid
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_bad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> addr == '0);

    assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !invalid) |->
            (addr[AW-1:AW-3] == $past(orient) && addr[AW-4:AW-5] == $past(fmt)));

    assert_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(fmt) == 2'd3) |-> (invalid && stride == '0));

    assert_stride_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(fmt) != 2'd3) |-> $countones(stride) == 1);

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $stable(fmt) && $stable(orient) && $past(primed)) |->
            $countones(stride) == $countones($past(stride)) || $past(fmt) != $past(fmt, 2));
endmodule

bind tiled_addr_gen tva_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .orient(orient),
    .addr(addr), .stride(stride), .invalid(invalid)
);

// File: tb/sim_tiled_addr_gen.sv
module sim_tiled_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = '0;
    logic [2:0]  orient = '0;
    logic [15:0] x = '0;
    logic [15:0] y = '0;
    logic [31:0] addr, stride;
    logic        invalid;
    int          n_run = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    tiled_addr_gen u0 (.clk(clk), .rst_n(rst_n), .fmt(fmt), .orient(orient),
        .x(x), .y(y), .addr(addr), .stride(stride), .invalid(invalid));

    task automatic model(input logic [1:0] f, input logic [2:0] o,
                         input int xi, input int yi,
                         output logic [31:0] ea, output logic [31:0] es, output logic ei);
        int xs, ys, xb, yb, xm, ym, xx, yy;
        longint off;
        xs = (f == 2) ? 1 : 0;
        ys = (f == 0) ? 0 : 1;
        xb = 14 - xs; yb = 13 - ys;
        xm = (1 << xb) - 1; ym = (1 << yb) - 1;
        if (f == 2'd3) begin
            ea = 0; es = 0; ei = 1; return;
        end
        es = o[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
        ei = (xi > xm) || (yi > ym);
        if (ei) begin ea = 0; return; end
        xx = o[0] ? xm - xi : xi;
        yy = o[1] ? ym - yi : yi;
        off = o[2] ? ((longint'(xx) << yb) + yy) : ((longint'(yy) << xb) + xx);
        off = off << (xs + ys);
        ea = {o, f, off[26:0]};
    endtask

    task automatic check(input string tag, input logic [31:0] a, input logic [31:0] s,
                         input logic i);
        n_run++;
        if (addr !== a || stride !== s || invalid !== i) begin
            n_bad++;
            $display("FAIL %s: addr=%h stride=%h inv=%b expected addr=%h stride=%h inv=%b",
                     tag, addr, stride, invalid, a, s, i);
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] f, input logic [2:0] o,
                         input int xi, input int yi);
        logic [31:0] ea, es; logic ei;
        @(negedge clk);
        fmt = f; orient = o; x = 16'(xi); y = 16'(yi);
        model(f, o, xi, yi, ea, es, ei);
        @(negedge clk);
        check(tag, ea, es, ei);
    endtask

    task automatic test_reset;
        @(negedge clk);
        fmt = 2'd2; orient = 3'd5; x = 16'd7; y = 16'd9;
        @(negedge clk);
        check("R1 reset", 32'd0, 32'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic test_latency;
        logic [31:0] ea, es; logic ei;
        apply("R1 settle", 2'd0, 3'd0, 5, 6);
        model(2'd0, 3'd0, 5, 6, ea, es, ei);
        @(negedge clk);
        fmt = 2'd1; orient = 3'd4; x = 16'd100; y = 16'd200;
        #2;
        check("R1 hold before edge", ea, es, ei);
        model(2'd1, 3'd4, 100, 200, ea, es, ei);
        @(negedge clk);
        check("R1 after edge", ea, es, ei);
    endtask

    task automatic test_formats;
        apply("R2 R3 R8 fmt0", 2'd0, 3'd0, 1234, 567);
        apply("R2 R3 R8 fmt1", 2'd1, 3'd0, 1234, 567);
        apply("R2 R3 R8 fmt2", 2'd2, 3'd0, 1234, 567);
        @(negedge clk); fmt = 0; orient = 0; x = 1; y = 1;
        @(negedge clk); check("R8 literal fmt0", 32'h0000_4001, 32'h0000_4000, 1'b0);
        @(negedge clk); fmt = 2; orient = 0; x = 1; y = 0;
        @(negedge clk); check("R2 R8 literal fmt2", 32'h1000_0004, 32'h0000_8000, 1'b0);
    endtask

    task automatic test_mirror;
        for (int o = 0; o < 4; o++) begin
            apply("R6 mirror fmt0", 2'd0, 3'(o), 300, 77);
            apply("R6 mirror fmt2", 2'd2, 3'(o), 4000, 2048);
        end
    endtask

    task automatic test_flip;
        for (int o = 4; o < 8; o++) begin
            apply("R7 R9 flip fmt0", 2'd0, 3'(o), 9, 4095);
            apply("R7 R9 flip fmt1", 2'd1, 3'(o), 16383, 4095);
            apply("R7 R9 flip fmt2", 2'd2, 3'(o), 8191, 1);
        end
    endtask

    task automatic test_bounds;
        apply("R4 fmt0 xmax ok", 2'd0, 3'd0, 16383, 8191);
        apply("R4 fmt0 x over", 2'd0, 3'd0, 16384, 0);
        apply("R4 fmt0 y over", 2'd0, 3'd3, 0, 8192);
        apply("R4 fmt1 y edge ok", 2'd1, 3'd0, 0, 4095);
        apply("R4 fmt1 y over", 2'd1, 3'd6, 0, 4096);
        apply("R4 fmt2 x edge ok", 2'd2, 3'd1, 8191, 4095);
        apply("R4 R9 fmt2 x over", 2'd2, 3'd4, 8192, 0);
    endtask

    task automatic test_rsvd;
        apply("R5 rsvd small", 2'd3, 3'd0, 1, 1);
        apply("R5 rsvd flip", 2'd3, 3'd7, 0, 0);
    endtask

    initial begin
        test_reset();
        test_latency();
        test_formats();
        test_mirror();
        test_flip();
        test_bounds();
        test_rsvd();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_bad++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule